// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital serial port of a sigma-delta converter operated from a host-driven serial clock, one conversion per frame. It sits between an abstract conversion core and the four-wire serial pins. The core raises a one-cycle done strobe with its result word. The port then puts the converter to sleep and holds that word until the host reads it. While chip select is low, the data line reports whether a conversion is running, so the host can poll it or use it as an interrupt.

Chip select, serial clock and serial data in arrive asynchronously. They pass through synchronizers into the system clock domain, where serial clock edges are found. A frame is 32 serial clock periods long. Its first bit is the live conversion status. Its second bit is a constant zero. The remaining bits are the held result, most significant bit first. The first bits the host shifts in during the frame become the configuration word. That word is applied to the conversion that the 32nd falling edge launches. A frame cut short by chip select rising starts nothing, and the next frame reads the same result again. The data line is driven as a value plus an enable; the tri-state buffer sits at the pad.

Top module: `adc_sif_port`

## Requirements
- R1: After reset, `busy_o` is 0, `start_o` is 0, `cfg_o` is 0, `sdo_oe_o` is 0, and the held result is 0.
- R2: `sdo_oe_o` is 0 while chip select is high and 1 while it is low, with the synchronizer latency.
- R3: With chip select low and no frame bit yet shifted, `sdo_o` is 1 while a conversion runs and 0 while asleep.
- R4: `done_i` while busy clears `busy_o` on the next cycle and captures `result_i`, whatever the level of chip select. `done_i` while asleep is ignored and the held result stays unchanged.
- R5: Frame bit 31 is the status, bit 30 is 0, and bits 29..0 are the held result from MSB to LSB. Each bit appears after a falling serial clock edge and is valid at the following rising edge; bit 31 is valid at the first rising edge.
- R6: The 32nd falling edge of a frame raises `start_o` for exactly one cycle, sets `busy_o` to 1 and makes `sdo_o` read 1.
- R7: `sdi_i` is sampled on the first CFG_W rising edges of a frame, MSB first. `cfg_o` changes only at the `start_o` pulse that ends the frame.
- R8: If chip select rises before the 32nd falling edge, the bit position resets, no conversion starts, and the next frame reads the same result again from the status bit.
- R9: Serial clock edges while busy are ignored: no bit position advances and no conversion starts.
- R10: With chip select held low after a frame, `sdo_o` drops from 1 to 0 when the conversion completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sdi_i | input | 1 | Serial configuration data from host |
| done_i | input | 1 | Conversion-complete strobe from core |
| result_i | input | RES_W | Result word from core, valid with done_i |
| sdo_o | output | 1 | Serial data / status value |
| sdo_oe_o | output | 1 | Pad enable for sdo_o; 0 means high impedance |
| busy_o | output | 1 | Conversion in progress |
| start_o | output | 1 | One-cycle pulse launching a conversion |
| cfg_o | output | CFG_W | Configuration for the launched conversion |

## Verification
The bench builds the port at its default size: a 30-bit result, which gives the full 32-bit frame, a 5-bit configuration word and two synchronizer stages. Serial clock phases last eight system cycles. Every synchronized edge therefore settles before the bench samples. The bench sweeps many result words, arithmetic patterns and walking ones, each paired with a different configuration word. Together they set and clear every frame position and every configuration bit. Aborted frames of several lengths, clocking while busy and done strobes while asleep exercise the ignore and restart paths.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  typedef enum logic {ST_SLEEP = 1'b0, ST_CONV = 1'b1} conv_st_e;

  function automatic int unsigned pos_w(int unsigned frame_w);
    return (frame_w < 2) ? 1 : $clog2(frame_w);
  endfunction
endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned N       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [N-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {N{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < N; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[N-1];
endmodule

// File: rtl/adc_sif_shift.sv
module adc_sif_shift #(
  parameter int unsigned RES_W = 30,
  parameter int unsigned POS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             rewind_i,
  input  logic             shift_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             busy_i,
  output logic             sdo_o
);
  logic [RES_W-1:0] res_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      sh_q  <= '0;
    end else if (load_i) begin
      res_q <= result_i;
      sh_q  <= result_i;
    end else if (rewind_i) begin
      sh_q <= res_q;
    end else if (shift_i) begin
      sh_q <= {sh_q[RES_W-2:0], 1'b0};
    end
  end

  // position 0: status, 1: fixed zero, then result MSB first
  always_comb begin
    if (pos_i == '0)                 sdo_o = busy_i;
    else if (pos_i == POS_W'(1))     sdo_o = 1'b0;
    else                             sdo_o = sh_q[RES_W-1];
  end

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i && !rewind_i) |=> $stable(sh_q));
  a_r4_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(res_q));
endmodule

// File: rtl/adc_sif_port.sv
module adc_sif_port
  import adc_sif_pkg::*;
#(
  parameter int unsigned RES_W  = 30,
  parameter int unsigned CFG_W  = 5,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             busy_o,
  output logic             start_o,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int unsigned FRAME_W = RES_W + 2;
  localparam int unsigned POS_W   = pos_w(FRAME_W);

  logic       cs_s, sck_s, sdi_s, sck_q;
  logic [2:0] sync_q;

  adc_sif_sync #(.W(3), .N(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sdi_i}),
    .q_o    (sync_q)
  );
  assign {cs_s, sck_s, sdi_s} = sync_q;

  conv_st_e         st_q;
  logic [POS_W-1:0] pos_q;
  logic [CFG_W-1:0] cfg_sh_q;
  logic             sleep, sck_rise, sck_fall, last_fall, shift, load;

  assign sleep     = (st_q == ST_SLEEP);
  assign sck_rise  = !cs_s && sleep &&  sck_s && !sck_q;
  assign sck_fall  = !cs_s && sleep && !sck_s &&  sck_q;
  assign last_fall = sck_fall && (pos_q == POS_W'(FRAME_W - 1));
  assign shift     = sck_fall && (pos_q >= POS_W'(2));
  assign load      = done_i && !sleep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      st_q     <= ST_SLEEP;
      pos_q    <= '0;
      cfg_sh_q <= '0;
      cfg_o    <= '0;
      start_o  <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      start_o <= 1'b0;
      if (load) st_q <= ST_SLEEP;
      if (cs_s) begin
        pos_q <= '0;
      end else if (last_fall) begin
        pos_q   <= '0;
        st_q    <= ST_CONV;
        start_o <= 1'b1;
        cfg_o   <= cfg_sh_q;
      end else if (sck_fall) begin
        pos_q <= pos_q + POS_W'(1);
      end
      if (sck_rise && pos_q < POS_W'(CFG_W))
        cfg_sh_q <= {cfg_sh_q[CFG_W-2:0], sdi_s};
    end
  end

  adc_sif_shift #(.RES_W(RES_W), .POS_W(POS_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .result_i (result_i),
    .rewind_i (cs_s),
    .shift_i  (shift),
    .pos_i    (pos_q),
    .busy_i   (!sleep),
    .sdo_o    (sdo_o)
  );

  assign busy_o   = !sleep;
  assign sdo_oe_o = !cs_s;

  a_r8_idle_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> pos_q == '0);
  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  a_r6_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o);
  a_r6_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r4_done_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_o) |=> !busy_o);
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> pos_q == '0);
  a_r7_cfg_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> start_o);
endmodule

// File: tb/test_adc_sif_port.sv
module test_adc_sif_port;
  localparam int RES_W = 30;
  localparam int CFG_W = 5;
  localparam int PH    = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, sdi = 1'b0, done = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic sdo, sdo_oe, busy, start;
  logic [CFG_W-1:0] cfg;

  int checks = 0, errors = 0, starts = 0, cyc = 0;

  always #4 clk = ~clk;

  adc_sif_port #(.RES_W(RES_W), .CFG_W(CFG_W), .SYNC_N(2)) i_adc_sif_port (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .done_i(done), .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .busy_o(busy), .start_o(start), .cfg_o(cfg)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start) starts <= starts + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: cycles %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_conv(input logic [RES_W-1:0] v);
    result = v; done = 1'b1;
    wait_clk(1);
    done = 1'b0;
    wait_clk(1);
  endtask

  // full frame read: expects asleep with result res, shifts in cfg_in
  task automatic read_frame(input logic [RES_W-1:0] res, input logic [CFG_W-1:0] cfg_in,
                            input logic [CFG_W-1:0] cfg_prev);
    logic [31:0] got;
    int s0;
    got = '0;
    s0 = starts;
    cs_ni = 1'b0;
    wait_clk(PH);
    for (int k = 0; k < 32; k++) begin
      sdi = (k < CFG_W) ? cfg_in[CFG_W-1-k] : 1'b0;
      wait_clk(PH);
      got[31-k] = sdo;
      sck = 1'b1;
      wait_clk(PH);
      if (k == 31) chk(cfg == cfg_prev, "R7 cfg held during frame", 64'(cfg), 64'(cfg_prev));
      sck = 1'b0;
    end
    wait_clk(PH);
    chk(got == {1'b0, 1'b0, res}, "R5 frame content", 64'(got), 64'({2'b00, res}));
    chk(starts == s0 + 1, "R6 one start pulse", 64'(starts - s0), 64'd1);
    chk(busy == 1'b1, "R6 busy after frame", 64'(busy), 64'd1);
    chk(sdo == 1'b1, "R6 sdo status after frame", 64'(sdo), 64'd1);
    chk(cfg == cfg_in, "R7 cfg applied", 64'(cfg), 64'(cfg_in));
  endtask

  task automatic abort_frame(input int n);
    int s0;
    s0 = starts;
    cs_ni = 1'b0;
    wait_clk(PH);
    for (int k = 0; k < n; k++) begin
      wait_clk(PH); sck = 1'b1; wait_clk(PH); sck = 1'b0;
    end
    wait_clk(PH);
    cs_ni = 1'b1;
    wait_clk(PH);
    chk(starts == s0, "R8 no start on abort", 64'(starts - s0), 64'd0);
    chk(busy == 1'b0, "R8 asleep after abort", 64'(busy), 64'd0);
  endtask

  initial begin
    logic [RES_W-1:0] v, held;
    logic [CFG_W-1:0] c, cprev;
    wait_clk(3);
    chk(busy == 1'b0 && start == 1'b0, "R1 busy/start reset", 64'({busy, start}), 64'd0);
    chk(cfg == '0, "R1 cfg reset", 64'(cfg), 64'd0);
    chk(sdo_oe == 1'b0, "R1 oe reset", 64'(sdo_oe), 64'd0);
    rst_ni = 1'b1;
    wait_clk(PH);
    chk(sdo_oe == 1'b0, "R2 high impedance with cs high", 64'(sdo_oe), 64'd0);
    cs_ni = 1'b0;
    wait_clk(PH);
    chk(sdo_oe == 1'b1, "R2 driven with cs low", 64'(sdo_oe), 64'd1);
    chk(sdo == 1'b0, "R3 asleep status", 64'(sdo), 64'd0);
    cs_ni = 1'b1;
    wait_clk(PH);
    read_frame('0, 5'h13, 5'h00);   // R1 held result zero
    cprev = 5'h13;

    // R9: clocking while busy, cs low
    for (int k = 0; k < 40; k++) begin
      wait_clk(PH); sck = 1'b1; wait_clk(PH); sck = 1'b0;
    end
    wait_clk(PH);
    chk(busy == 1'b1, "R9 still busy", 64'(busy), 64'd1);
    chk(sdo == 1'b1, "R3 busy status", 64'(sdo), 64'd1);
    chk(starts == 1, "R9 no extra start", 64'(starts), 64'd1);
    // R10: interrupt with cs held low
    finish_conv(30'h2345_6789);
    wait_clk(PH);
    chk(sdo == 1'b0, "R10 sdo drops on completion", 64'(sdo), 64'd0);
    chk(busy == 1'b0, "R4 done clears busy", 64'(busy), 64'd0);
    cs_ni = 1'b1;
    wait_clk(PH);
    // R4: done while asleep ignored
    finish_conv(30'h0ABC_DEF0);
    chk(busy == 1'b0, "R4 ignored done keeps sleep", 64'(busy), 64'd0);
    held = 30'h2345_6789;
    // R8 aborts of several lengths
    abort_frame(1);
    abort_frame(10);
    abort_frame(31);
    read_frame(held, 5'h0A, cprev);
    cprev = 5'h0A;

    for (int i = 0; i < 32; i++) begin
      if (i < RES_W) v = (i[0]) ? (RES_W'(1) << i) : RES_W'(32'h1555_5555 * (i + 3) ^ (i * 32'h0007_3F21));
      else v = (i == 30) ? '1 : '0;
      c = CFG_W'((i * 7 + 1) % 32);
      finish_conv(v);
      chk(busy == 1'b0, "R4 done accepted", 64'(busy), 64'd0);
      read_frame(v, c, cprev);
      cprev = c;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule